// File: doc/BRIEF.md
# Fast PWM Timer with Buffered Compare

This block is an up-counting timer that runs in single-slope fast PWM mode and drives one waveform output. A prescaler divides the I/O clock by a selectable factor to make the timer tick. On each tick the counter steps from 0 up to its all-ones maximum and then wraps to 0, so one PWM period is 256 ticks. The counter value is compared against an active compare value. A two-bit output mode sets, clears or toggles the output latch on a compare match and on the wrap.

Software writes the compare value into a buffer through a small register port. The buffer is copied into the active compare value only at the counter maximum, so a write in the middle of a period cannot cut a pulse short. An overflow flag and a compare flag record the two timer events. Each flag is cleared by writing a 1 to it, and each can raise an interrupt request when its enable bit is set. The output level appears on the pin only while the direction input is high.

Register map, 2-bit address: 0 = control (bits [2:0] clock select, bits [5:4] output mode), 1 = counter (read only), 2 = compare buffer, 3 = status and enable (bit 0 overflow flag, bit 1 compare flag, bit 4 overflow interrupt enable, bit 5 compare interrupt enable). Register reads are combinational.

Top module: `fpwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, and `pin_out`, `irq_ovf` and `irq_cmp` are 0.
- R2: Clock select (control bits [2:0]) value 0 stops the counter. Values 1 to 7 pick a divider N of 1, 8, 32, 64, 128, 256 or 1024, and the counter then advances once every N clocks.
- R3: A control write that changes the clock select restarts the prescaler, so the first counter step comes exactly N clocks after the write edge.
- R4: The counter runs from 0 to 255 and the tick after 255 returns it to 0.
- R5: In output mode 2 (control bits [5:4] = 2, non-inverted), once one full period has run with the active compare value C, the pin is high while the counter reads 0..C and low otherwise. So C = 255 gives a constant high, and C = 0 gives a one-tick pulse each period.
- R6: In output mode 3 (inverted), the pin is the complement of the mode 2 level for the same counter value and C. So C = 255 gives a constant low.
- R7: In output mode 1, the output latch toggles on each compare match. The pin changes only on the step from counter C to C+1, which gives a square wave with a period of 512 ticks.
- R8: The pin is 0 whenever `pin_oe` is 0 or the output mode is 0.
- R9: A write to address 2 updates the compare buffer, which reads back at once. The active compare value takes the buffer only on the tick where the counter holds 255, so the current period finishes with the old value.
- R10: Status bit 0 sets on the tick where the counter holds 255 and is first readable when the counter reads 0. Writing 1 to that bit clears it. `irq_ovf` equals the flag ANDed with enable bit 4.
- R11: Status bit 1 sets on the tick where the counter equals the active compare value and is first readable when the counter reads C+1. Writing 1 to that bit clears it. `irq_cmp` equals the flag ANDed with enable bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_oe | input | 1 | Output direction; 1 lets the waveform reach the pin |
| pin_out | output | 1 | Waveform output pin level |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare-match interrupt request |

## Verification
Every timer result is registered on the same edge that advances the counter, so the pin level and both flags belong to the counter value read in the same cycle. A match at count C shows up together with count C+1, and the overflow shows up together with count 0. The bench therefore lines each check up against the counter value it reads back, not against a cycle count. Inputs and samples change only at the falling clock edge. The one check tied to wall-clock cycles is the prescaler restart: the counter must hold for N-1 falling edges after the write edge and step at the N-th.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } fpwm_mode_e;

    // log2 of the prescale divider for each clock-select code (0 = stopped)
    function automatic int unsigned div_shift(input logic [2:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
    parameter int PSC_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       clr,
    output logic       tick
);
    import fpwm_pkg::*;

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_t;

    psc_t             s_d, s_q;
    logic [PSC_W-1:0] term;
    logic             run;

    always_comb begin
        s_d  = s_q;
        run  = (sel != 3'd0);
        term = PSC_W'((32'd1 << div_shift(sel)) - 32'd1);
        tick = run && !clr && (s_q.cnt == term);
        if (clr || !run || (s_q.cnt == term))
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_buf,
    output logic             at_top,
    output logic             at_match
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] buff;
        logic [CNT_W-1:0] act;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        at_top   = tick && (s_q.cnt == CNT_MAX);
        at_match = tick && (s_q.cnt == s_q.act);
        if (tick)   s_d.cnt  = s_q.cnt + 1'b1;
        if (cmp_wr) s_d.buff = cmp_wdata;
        if (at_top) s_d.act  = s_q.buff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign cmp_buf = s_q.buff;

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));

    // R9
    act_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !at_top |=> $stable(s_q.act));

endmodule

// File: rtl/fpwm_wavegen.sv
module fpwm_wavegen (
    input  logic                clk,
    input  logic                rst_n,
    input  fpwm_pkg::fpwm_mode_e mode,
    input  logic                at_top,
    input  logic                at_match,
    output logic                oc
);
    import fpwm_pkg::*;

    typedef struct packed {
        logic oc;
    } wg_t;

    wg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (mode)
            OM_TOGGLE: if (at_match) s_d.oc = !s_q.oc;
            OM_NONINV: begin
                if (at_top)        s_d.oc = 1'b1;
                else if (at_match) s_d.oc = 1'b0;
            end
            OM_INV: begin
                if (at_top)        s_d.oc = 1'b0;
                else if (at_match) s_d.oc = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oc = s_q.oc;

    // R5
    noninv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_NONINV && at_top) |=> oc);

    // R6
    inv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_INV && at_top) |=> !oc);

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_TOGGLE && at_match) |=> (oc != $past(oc)));

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
    parameter int CNT_W = 8,
    parameter int PSC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             pin_oe,
    output logic             pin_out,
    output logic             irq_ovf,
    output logic             irq_cmp
);
    import fpwm_pkg::*;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic [2:0] sel;
        fpwm_mode_e mode;
        logic       ovf_f;
        logic       cmp_f;
        logic       ovf_ie;
        logic       cmp_ie;
    } regs_t;

    regs_t            r_d, r_q;
    logic             psc_clr, cmp_wr, tick, at_top, at_match, oc;
    logic [CNT_W-1:0] count, cmp_buf;

    always_comb begin
        r_d     = r_q;
        psc_clr = 1'b0;
        cmp_wr  = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    r_d.sel  = reg_wdata[2:0];
                    r_d.mode = fpwm_mode_e'(reg_wdata[5:4]);
                    psc_clr  = (reg_wdata[2:0] != r_q.sel);
                end
                A_CMP:  cmp_wr = 1'b1;
                A_STAT: begin
                    r_d.ovf_ie = reg_wdata[4];
                    r_d.cmp_ie = reg_wdata[5];
                    if (reg_wdata[0]) r_d.ovf_f = 1'b0;
                    if (reg_wdata[1]) r_d.cmp_f = 1'b0;
                end
                default: ;
            endcase
        end
        if (at_top)   r_d.ovf_f = 1'b1;
        if (at_match) r_d.cmp_f = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[2:0] = r_q.sel;
                reg_rdata[5:4] = r_q.mode;
            end
            A_CNT:  reg_rdata = count;
            A_CMP:  reg_rdata = cmp_buf;
            default: begin
                reg_rdata[0] = r_q.ovf_f;
                reg_rdata[1] = r_q.cmp_f;
                reg_rdata[4] = r_q.ovf_ie;
                reg_rdata[5] = r_q.cmp_ie;
            end
        endcase
    end

    assign pin_out = pin_oe && (r_q.mode != OM_OFF) && oc;
    assign irq_ovf = r_q.ovf_f && r_q.ovf_ie;
    assign irq_cmp = r_q.cmp_f && r_q.cmp_ie;

    fpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (r_q.sel),
        .clr   (psc_clr),
        .tick  (tick)
    );

    fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (reg_wdata),
        .count     (count),
        .cmp_buf   (cmp_buf),
        .at_top    (at_top),
        .at_match  (at_match)
    );

    fpwm_wavegen u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (r_q.mode),
        .at_top   (at_top),
        .at_match (at_match),
        .oc       (oc)
    );

    // R10
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ovf_f) |-> $past(at_top));

    // R11
    cmp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cmp_f) |-> $past(at_match));

    // R3
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_clr && reg_wdata[2:0] != 3'd1) |=> !tick);

endmodule

// File: tb/fpwm_timer_tb.sv
module fpwm_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pin_oe = 1'b0;
    logic       pin_out, irq_ovf, irq_cmp;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fpwm_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .irq_ovf   (irq_ovf),
        .irq_cmp   (irq_cmp)
    );

    // {mode[1:0], compare[7:0], oe}
    localparam logic [10:0] VEC [10] = '{
        {2'd2, 8'h80, 1'b1},
        {2'd2, 8'h00, 1'b1},
        {2'd2, 8'hFF, 1'b1},
        {2'd2, 8'h3C, 1'b1},
        {2'd3, 8'h40, 1'b1},
        {2'd3, 8'hFF, 1'b1},
        {2'd3, 8'h00, 1'b1},
        {2'd2, 8'h80, 1'b0},
        {2'd3, 8'h20, 1'b0},
        {2'd0, 8'h80, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 2'd1;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd1;
        #1;
    endtask

    task automatic wait_cnt(input logic [7:0] target);
        bit hit = 1'b0;
        for (int i = 0; i < 3000 && !hit; i++) begin
            @(negedge clk);
            #1;
            if (reg_rdata == target) hit = 1'b1;
        end
        if (!hit) chk("R4 counter reach", 32'(reg_rdata), 32'(target));
    endtask

    function automatic logic exp_pin(input logic [1:0] m, input logic [7:0] c,
                                     input logic oe, input logic [7:0] n);
        logic hi;
        hi = (n <= c);
        if (!oe || m == 2'd0) return 1'b0;
        if (m == 2'd2) return hi;
        if (m == 2'd3) return !hi;
        return 1'b0;
    endfunction

    task automatic div_test(input logic [2:0] sel, input int n);
        logic [7:0] c0;
        int errs = 0;
        wr(2'd0, {2'b00, 2'b10, 1'b0, sel});
        c0 = reg_rdata;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            #1;
            if (reg_rdata != c0) errs++;
        end
        chk($sformatf("R3 hold before first step N=%0d", n), 32'(errs), 32'd0);
        @(negedge clk);
        #1;
        chk($sformatf("R2 step after N=%0d clocks", n), 32'(reg_rdata), 32'(c0 + 8'd1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, c0;
        logic p1, p2, p3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), 32'(d), 32'd0);
        end
        chk("R1 pin after reset", 32'(pin_out), 32'd0);
        chk("R1 irqs after reset", 32'({irq_ovf, irq_cmp}), 32'd0);
        repeat (20) @(negedge clk);
        #1;
        chk("R1 counter stopped", 32'(reg_rdata), 32'd0);

        // R5 R6 R8 vector walk, N=1
        for (int v = 0; v < 10; v++) begin
            logic [1:0] m;
            logic [7:0] c;
            logic oe;
            int errs;
            {m, c, oe} = VEC[v];
            wr(2'd0, {2'b00, m, 1'b0, 3'd1});
            wr(2'd2, c);
            pin_oe = oe;
            repeat (520) @(negedge clk);
            errs = 0;
            for (int k = 0; k < 256; k++) begin
                @(negedge clk);
                #1;
                if (pin_out != exp_pin(m, c, oe, reg_rdata)) begin
                    if (errs == 0)
                        $display("FAIL R5/R6/R8 vec %0d cnt=%0h actual=%0b expected=%0b",
                                 v, reg_rdata, pin_out, exp_pin(m, c, oe, reg_rdata));
                    errs++;
                end
            end
            total++;
            if (errs != 0) bad++;
        end

        // R4 wrap
        wait_cnt(8'hFF);
        @(negedge clk);
        #1;
        chk("R4 wrap 255 to 0", 32'(reg_rdata), 32'd0);

        // R9 double buffer (mode 2, active 0x80)
        pin_oe = 1'b1;
        wr(2'd0, 8'h21);
        wr(2'd2, 8'h80);
        repeat (520) @(negedge clk);
        wait_cnt(8'h10);
        wr(2'd2, 8'h20);
        rd(2'd2, d);
        chk("R9 buffer readback", 32'(d), 32'h20);
        wait_cnt(8'h30);
        chk("R9 old compare kept at 0x30", 32'(pin_out), 32'd1);
        wait_cnt(8'h90);
        chk("R9 old compare kept at 0x90", 32'(pin_out), 32'd0);
        wait_cnt(8'h30);
        chk("R9 new compare after wrap", 32'(pin_out), 32'd0);
        wait_cnt(8'h10);
        chk("R9 new compare high region", 32'(pin_out), 32'd1);

        // R7 toggle mode, compare 0
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h11);
        repeat (600) @(negedge clk);
        wait_cnt(8'h02);
        p1 = pin_out;
        wait_cnt(8'h00);
        p2 = pin_out;
        chk("R7 stable between matches", 32'(p2), 32'(p1));
        @(negedge clk);
        #1;
        p3 = pin_out;
        chk("R7 toggles at match", 32'(p3), 32'(!p2));

        // R10 overflow flag
        wait_cnt(8'h10);
        wr(2'd3, 8'h03);
        rd(2'd3, d);
        chk("R10 flag cleared by write 1", 32'(d[0]), 32'd0);
        wait_cnt(8'hFF);
        rd(2'd3, d);
        chk("R10 flag clear at 255", 32'(d[0]), 32'd0);
        @(negedge clk);
        #1;
        chk("R10 count is 0", 32'(reg_rdata), 32'd0);
        rd(2'd3, d);
        chk("R10 flag set at count 0", 32'(d[0]), 32'd1);
        chk("R10 irq masked", 32'(irq_ovf), 32'd0);
        wr(2'd3, 8'h10);
        chk("R10 irq enabled", 32'(irq_ovf), 32'd1);
        wr(2'd3, 8'h11);
        chk("R10 irq after clear", 32'(irq_ovf), 32'd0);

        // R11 compare flag, active 0x80
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h21);
        repeat (300) @(negedge clk);
        wait_cnt(8'h10);
        wr(2'd3, 8'h02);
        wait_cnt(8'h80);
        rd(2'd3, d);
        chk("R11 flag clear at compare value", 32'(d[1]), 32'd0);
        @(negedge clk);
        #1;
        rd(2'd3, d);
        chk("R11 flag set at compare+1", 32'(d[1]), 32'd1);
        chk("R11 irq masked", 32'(irq_cmp), 32'd0);
        wr(2'd3, 8'h20);
        chk("R11 irq enabled", 32'(irq_cmp), 32'd1);
        wr(2'd3, 8'h22);
        chk("R11 irq after clear", 32'(irq_cmp), 32'd0);

        // R2 R3 dividers
        div_test(3'd2, 8);
        div_test(3'd3, 32);
        div_test(3'd7, 1024);

        // R2 stop
        wr(2'd0, 8'h20);
        c0 = reg_rdata;
        repeat (50) @(negedge clk);
        #1;
        chk("R2 stopped counter holds", 32'(reg_rdata), 32'(c0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule